// File: doc/BRIEF.md
# User Glyph RAM Write Port

This block stores a small set of user-defined glyphs: 16 glyph codes, each with 7 pixel rows of 5 pixels. A host loads a 7-bit pointer whose upper four bits name the glyph code and whose lower three bits name the row. It then writes pixel bytes, and only the five low bits of each byte are kept. When stepping is enabled, the pointer advances by one after every pixel write. This lets a host stream a whole glyph, or a run of glyphs, after a single pointer load.

Because the row field is three bits wide, stepping passes through an eighth row slot (row 7) that has no storage. A pixel write that lands there is accepted and discarded. The step that follows carries the pointer into row 0 of the next glyph code, so a host sends one filler byte per glyph.

A separate read port serves the display fetch logic. The fetch logic presents a glyph code and a row, and the stored 5-bit row appears one clock later.

Top module: `glyph_ram_wport`

## Requirements
- R1: After reset every stored row reads as 0 and the pointer is 0, so a pixel write made before any pointer load lands in code 0, row 0.
- R2: A pointer load takes `ptr_in[6:3]` as the glyph code and `ptr_in[2:0]` as the row, and the next pixel write is stored at that code and row.
- R3: A pixel write stores `pix_in[4:0]` only; bits 7 to 5 of the byte have no effect on what is stored.
- R4: With `step_en` high, the pointer increases by one after each pixel write, so consecutive writes fill consecutive rows.
- R5: With `step_en` low, repeated pixel writes all go to the same row, and the last one wins.
- R6: A pixel write while the row field is 7 leaves all storage unchanged. With stepping on, the following write lands in row 0 of the next glyph code.
- R7: Stepping from pointer 0x7F wraps to 0x00, which is code 0, row 0.
- R8: The read port returns, one clock after `fetch_code`/`fetch_row` are presented, the row stored there in bits [4:0] of `fetch_pix`. A fetch of row 7 returns 0.
- R9: When a pointer load and a pixel write arrive in the same cycle, the pixel goes to the old pointer and the loaded value becomes the new pointer; no step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_we | input | 1 | Load the pointer from `ptr_in` |
| ptr_in | input | 7 | Pointer value: [6:3] glyph code, [2:0] row |
| pix_we | input | 1 | Write one pixel row at the current pointer |
| pix_in | input | 8 | Pixel byte; bits [4:0] are stored |
| step_en | input | 1 | Advance the pointer after each pixel write |
| fetch_code | input | 4 | Glyph code to read |
| fetch_row | input | 3 | Row to read |
| fetch_pix | output | 5 | Row read, valid one clock after the request |

## Verification
A wrong pointer never shows directly. It surfaces as pixels stored in the wrong slot, which the read port exposes two clocks after the faulty write. A missed carry through the row-7 slot shifts every later glyph by one row. A discarded write that is in fact stored corrupts row 0 of the next code or another slot, and that also becomes visible on the next fetch of the affected slot. Stale or early read data shows up as a mismatch in the cycle right after a fetch request changes.

// File: rtl/glyph_ram_pkg.sv
package glyph_ram_pkg;
    localparam int CODE_W = 4;
    localparam int ROW_W  = 3;
    localparam int ROWS   = 7;
    localparam int PIX_W  = 5;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = CODE_W + ROW_W;
    localparam int CODES  = 1 << CODE_W;
    localparam int DEPTH  = CODES * ROWS;
    localparam int IDX_W  = $clog2(DEPTH);

    typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/glyph_ptr_ctrl.sv
module glyph_ptr_ctrl
    import glyph_ram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic [PTR_W-1:0]  ptr_in,
    input  logic              pix_we,
    input  logic [BYTE_W-1:0] pix_in,
    input  logic              step_en,
    output logic              wr_en,
    output logic [CODE_W-1:0] wr_code,
    output logic [ROW_W-1:0]  wr_row,
    output pix_t              wr_pix
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic unused_hi_bits;

    assign unused_hi_bits = ^pix_in[BYTE_W-1:PIX_W];

    always_comb begin
        st_d = st_q;
        if (pix_we && step_en) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        if (ptr_we) begin
            st_d.ptr = ptr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_code = st_q.ptr[PTR_W-1:ROW_W];
    assign wr_row  = st_q.ptr[ROW_W-1:0];
    assign wr_en   = pix_we && (int'(wr_row) < ROWS);
    assign wr_pix  = pix_in[PIX_W-1:0];

    // R2: a pointer load takes effect on the next cycle.
    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> (st_q.ptr == $past(ptr_in)));

    // R4 and R7: a write with stepping on advances the pointer by one, wrapping at the top.
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_we && step_en && !ptr_we) |=> (st_q.ptr == PTR_W'($past(st_q.ptr) + 1)));

    // R5: a write with stepping off leaves the pointer in place.
    a_r5_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_we && !step_en && !ptr_we) |=> $stable(st_q.ptr));

    // R6: the phantom row never produces a store.
    a_r6_phantom_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_row == ROW_W'(ROWS)) |-> !wr_en);
endmodule

// File: rtl/glyph_store.sv
module glyph_store
    import glyph_ram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [ROW_W-1:0]  wr_row,
    input  pix_t              wr_pix,
    input  logic [CODE_W-1:0] rd_code,
    input  logic [ROW_W-1:0]  rd_row,
    output pix_t              rd_pix
);
    typedef struct packed {
        logic [DEPTH-1:0][PIX_W-1:0] mem;
        pix_t                        rd;
    } store_state_t;

    store_state_t st_d, st_q;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             rd_ok;

    assign wr_idx = IDX_W'(wr_code) * IDX_W'(ROWS) + IDX_W'(wr_row);
    assign rd_idx = IDX_W'(rd_code) * IDX_W'(ROWS) + IDX_W'(rd_row);
    assign rd_ok  = (int'(rd_row) < ROWS);

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < DEPTH; e++) begin
            if (wr_en && (wr_idx == IDX_W'(e))) begin
                st_d.mem[e] = wr_pix;
            end
        end
        st_d.rd = rd_ok ? st_q.mem[rd_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_pix = st_q.rd;

    // R6: storage is untouched in a cycle with no store request.
    a_r6_no_store_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.mem));

    // R8: a fetch of the phantom row returns zero on the next cycle.
    a_r8_phantom_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_row == ROW_W'(ROWS)) |=> (rd_pix == '0));
endmodule

// File: rtl/glyph_ram_wport.sv
module glyph_ram_wport
    import glyph_ram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_we,
    input  logic [6:0]  ptr_in,
    input  logic        pix_we,
    input  logic [7:0]  pix_in,
    input  logic        step_en,
    input  logic [3:0]  fetch_code,
    input  logic [2:0]  fetch_row,
    output logic [4:0]  fetch_pix
);
    logic              wr_en;
    logic [CODE_W-1:0] wr_code;
    logic [ROW_W-1:0]  wr_row;
    pix_t              wr_pix;

    glyph_ptr_ctrl i_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_we  (ptr_we),
        .ptr_in  (ptr_in),
        .pix_we  (pix_we),
        .pix_in  (pix_in),
        .step_en (step_en),
        .wr_en   (wr_en),
        .wr_code (wr_code),
        .wr_row  (wr_row),
        .wr_pix  (wr_pix)
    );

    glyph_store i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_code (wr_code),
        .wr_row  (wr_row),
        .wr_pix  (wr_pix),
        .rd_code (fetch_code),
        .rd_row  (fetch_row),
        .rd_pix  (fetch_pix)
    );

    // R3: what reaches storage never carries the upper byte bits.
    a_r3_low_bits_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_pix == pix_in[4:0]));
endmodule

// File: tb/test_glyph_ram_wport.sv
module test_glyph_ram_wport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ptr_we = 1'b0;
    logic [6:0] ptr_in = '0;
    logic       pix_we = 1'b0;
    logic [7:0] pix_in = '0;
    logic       step_en = 1'b0;
    logic [3:0] fetch_code = '0;
    logic [2:0] fetch_row = '0;
    logic [4:0] fetch_pix;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    glyph_ram_wport i_glyph_ram_wport (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_in(ptr_in),
        .pix_we(pix_we), .pix_in(pix_in), .step_en(step_en),
        .fetch_code(fetch_code), .fetch_row(fetch_row), .fetch_pix(fetch_pix)
    );

    task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_ptr(logic [6:0] p);
        @(negedge clk);
        ptr_we = 1'b1; ptr_in = p;
        @(negedge clk);
        ptr_we = 1'b0;
    endtask

    task automatic put(logic [7:0] d);
        @(negedge clk);
        pix_we = 1'b1; pix_in = d;
        @(negedge clk);
        pix_we = 1'b0;
    endtask

    task automatic peek(string req, logic [3:0] c, logic [2:0] r, logic [4:0] exp);
        @(negedge clk);
        fetch_code = c; fetch_row = r;
        @(negedge clk);
        chk(req, fetch_pix, exp);
    endtask

    task automatic t_reset();
        peek("R1", 4'd0, 3'd0, 5'h00);
        peek("R1", 4'd15, 3'd6, 5'h00);
        step_en = 1'b0;
        put(8'h09);
        peek("R1", 4'd0, 3'd0, 5'h09);
    endtask

    task automatic t_load_mask_hold();
        step_en = 1'b0;
        load_ptr(7'h2B);
        put(8'hFF);
        peek("R3", 4'd5, 3'd3, 5'h1F);
        put(8'hEA);
        peek("R5", 4'd5, 3'd3, 5'h0A);
        peek("R2", 4'd5, 3'd4, 5'h00);
    endtask

    task automatic t_stream();
        step_en = 1'b1;
        load_ptr(7'h10);
        for (int i = 0; i < 7; i++) put(8'(8'h01 + i));
        put(8'h15);
        put(8'h11);
        for (int i = 0; i < 7; i++) peek("R4", 4'd2, 3'(i), 5'(1 + i));
        peek("R6", 4'd3, 3'd0, 5'h11);
        peek("R6", 4'd3, 3'd1, 5'h00);
        peek("R8", 4'd2, 3'd7, 5'h00);
    endtask

    task automatic t_wrap();
        step_en = 1'b1;
        load_ptr(7'h7E);
        put(8'h0C);
        put(8'h1D);
        put(8'h0E);
        peek("R7", 4'd15, 3'd6, 5'h0C);
        peek("R7", 4'd0, 3'd0, 5'h0E);
    endtask

    task automatic t_collide();
        step_en = 1'b1;
        load_ptr(7'h08);
        @(negedge clk);
        ptr_we = 1'b1; ptr_in = 7'h40; pix_we = 1'b1; pix_in = 8'h03;
        @(negedge clk);
        ptr_we = 1'b0; pix_we = 1'b0;
        step_en = 1'b0;
        put(8'h04);
        peek("R9", 4'd1, 3'd0, 5'h03);
        peek("R9", 4'd8, 3'd0, 5'h04);
    endtask

    task automatic t_latency();
        @(negedge clk);
        fetch_code = 4'd5; fetch_row = 3'd3;
        @(negedge clk);
        chk("R8", fetch_pix, 5'h0A);
        fetch_code = 4'd8; fetch_row = 3'd0;
        #5;
        chk("R8", fetch_pix, 5'h0A);
        @(negedge clk);
        chk("R8", fetch_pix, 5'h04);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_mask_hold();
        t_stream();
        t_wrap();
        t_collide();
        t_latency();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule